// File: doc/BRIEF.md
# Split-Converter Backend Gain Equalizer

This block keeps the slope of one half of a split analog-to-digital converter equal to that of the other half. Converter A delivers its coarse contribution and its backend code separately. The block multiplies only the backend code by a learned unsigned gain word and adds the unscaled coarse part to form A's rescaled output. Converter B's corrected output is the reference. The block adapts only A's gain, with a sign-data LMS rule that drives the difference between the two converters' outputs on the same sample toward zero.

The error is kept at full precision, with the fraction bits of the product retained, so the gain can settle more finely than one output code allows. The step is a right shift chosen by the caller. A parameter sets a floor on that shift, which keeps this loop slower than the per-transition error averagers that run beside it. A freeze input holds the gain word. The gain word has one integer bit and FRAC_W fraction bits, starts at exactly 1.0, and saturates at both ends rather than wrapping.

Top module: `lms_gain_eq`

## Requirements
- R1: While rst is high the gain word equals 1.0 (only bit FRAC_W set) and outA equals 0. Both values are present at the first clock edge after reset is released.
- R2: At the clock edge where inValid is high, outA is loaded with coarseA + floor(backA * gain / 2^FRAC_W), using the gain held before that edge. Only the backend code is scaled.
- R3: When that sum falls outside the signed OUT_W range, outA takes the nearest limit: 2^(OUT_W-1)-1 above the range, or -2^(OUT_W-1) below it.
- R4: outA keeps its value at every edge where inValid is low.
- R5: Define the error as e = coarseA*2^FRAC_W + backA*gain - refB*2^FRAC_W for a sample. On the edge after that sample's capture edge, the gain word falls by floor(e / 2^k) when backA > 0. It rises by the same amount when backA < 0, and it is unchanged when backA = 0.
- R6: The shift k is stepShift when stepShift ≥ MIN_SHIFT, and MIN_SHIFT otherwise.
- R7: The updated gain saturates to the range 0 through 2^(FRAC_W+1)-1.
- R8: When freeze is high at the update edge, the gain word keeps its value.
- R9: The stimulus is a stream with refB = coarseA + floor(backA * G / 2^FRAC_W) for a fixed target gain G. With stepShift = 13 and |backA| up to 2000, the gain word ends within 96 LSB of G after 3000 samples.
- R10: The gain word changes only on the edge that follows a capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Marks a sample on backA, coarseA and refB |
| freeze | input | 1 | Holds the gain word at the update edge |
| stepShift | input | SHIFT_W | Adaptation shift, raised to MIN_SHIFT when lower |
| backA | input | BACK_W | Converter A backend code, signed |
| coarseA | input | OUT_W | Converter A coarse contribution, signed |
| refB | input | OUT_W | Converter B corrected output, signed |
| outA | output | OUT_W | Converter A rescaled output, signed |
| gain | output | FRAC_W+1 | Current gain word, unsigned, FRAC_W fraction bits |

## Verification
The checker assumes that inValid, backA, coarseA and freeze are low or zero while reset is held. It also assumes that freeze does not change between a capture edge and the update edge that follows it. The bench meets both conditions: it drives every input from a negative edge, clears everything during reset, and sets or releases freeze only between samples. Samples are spaced two cycles apart, so an update never coincides with a capture. This keeps each expected output tied to one known gain value.

// File: rtl/lms_eq_pkg.sv
package lms_eq_pkg;
  typedef struct packed {
    logic capture;
    logic update;
  } eq_strobe_t;
endpackage

// File: rtl/lms_eq_ctrl.sv
module lms_eq_ctrl
  import lms_eq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       freeze,
  output eq_strobe_t strobe
);
  logic validQ;

  always_ff @(posedge clk) begin
    if (rst) validQ <= 1'b0;
    else     validQ <= inValid;
  end

  always_comb begin
    strobe.capture = inValid;
    strobe.update  = validQ & ~freeze;
  end
endmodule

// File: rtl/lms_eq_datapath.sv
module lms_eq_datapath
  import lms_eq_pkg::*;
#(
  parameter int BACK_W    = 12,
  parameter int OUT_W     = 16,
  parameter int FRAC_W    = 16,
  parameter int SHIFT_W   = 5,
  parameter int MIN_SHIFT = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  eq_strobe_t               strobe,
  input  logic [SHIFT_W-1:0]       stepShift,
  input  logic signed [BACK_W-1:0] backA,
  input  logic signed [OUT_W-1:0]  coarseA,
  input  logic signed [OUT_W-1:0]  refB,
  output logic signed [OUT_W-1:0]  outA,
  output logic [FRAC_W:0]          gain
);
  localparam int G_W    = FRAC_W + 1;
  localparam int PROD_W = BACK_W + G_W + 1;
  localparam int SCL_W  = PROD_W - FRAC_W;
  localparam int SUM_W  = ((OUT_W > SCL_W) ? OUT_W : SCL_W) + 1;
  localparam int FINE_W = (((OUT_W + FRAC_W) > PROD_W) ? (OUT_W + FRAC_W) : PROD_W) + 2;
  localparam int UPD_W  = FINE_W + 1;
  localparam logic signed [SUM_W-1:0] O_MAX = SUM_W'((64'sd1 <<< (OUT_W-1)) - 1);
  localparam logic signed [SUM_W-1:0] O_MIN = SUM_W'(-(64'sd1 <<< (OUT_W-1)));
  localparam logic signed [UPD_W-1:0] G_MAX = UPD_W'((64'sd1 <<< G_W) - 1);
  localparam logic [G_W-1:0] G_ONE = G_W'(1) << FRAC_W;
  localparam logic [SHIFT_W-1:0] S_FLOOR = SHIFT_W'(MIN_SHIFT);

  logic [G_W-1:0]             gainQ;
  logic signed [OUT_W-1:0]    outQ;
  logic signed [FINE_W-1:0]   errQ;
  logic                       posQ, negQ;

  logic signed [PROD_W-1:0]   backX, gainX, prod;
  logic signed [SCL_W-1:0]    scaled;
  logic signed [SUM_W-1:0]    sumV;
  logic signed [OUT_W-1:0]    outNext;
  logic signed [FINE_W-1:0]   errNext;

  // scaled backend plus unscaled coarse part
  always_comb begin
    backX  = PROD_W'(backA);
    gainX  = PROD_W'($signed({1'b0, gainQ}));
    prod   = backX * gainX;
    scaled = SCL_W'(prod >>> FRAC_W);
    sumV   = SUM_W'(coarseA) + SUM_W'(scaled);
    if (sumV > O_MAX)      outNext = OUT_W'(O_MAX);
    else if (sumV < O_MIN) outNext = OUT_W'(O_MIN);
    else                   outNext = OUT_W'(sumV);
    errNext = (FINE_W'(coarseA) <<< FRAC_W) + FINE_W'(prod)
            - (FINE_W'(refB) <<< FRAC_W);
  end

  logic [SHIFT_W-1:0]        shiftEff;
  logic signed [FINE_W-1:0]  delta;
  logic signed [UPD_W-1:0]   gExt, gNew;
  logic [G_W-1:0]            gainNext;

  // sign-data LMS step with saturation
  always_comb begin
    shiftEff = (stepShift < S_FLOOR) ? S_FLOOR : stepShift;
    delta    = errQ >>> shiftEff;
    gExt     = UPD_W'($signed({1'b0, gainQ}));
    if (posQ)      gNew = gExt - UPD_W'(delta);
    else if (negQ) gNew = gExt + UPD_W'(delta);
    else           gNew = gExt;
    if (gNew < 0)          gainNext = '0;
    else if (gNew > G_MAX) gainNext = G_W'(G_MAX);
    else                   gainNext = G_W'(gNew);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outQ  <= '0;
      errQ  <= '0;
      posQ  <= 1'b0;
      negQ  <= 1'b0;
      gainQ <= G_ONE;
    end else begin
      if (strobe.capture) begin
        outQ <= outNext;
        errQ <= errNext;
        posQ <= (backA > 0);
        negQ <= (backA < 0);
      end
      if (strobe.update) gainQ <= gainNext;
    end
  end

  assign outA = outQ;
  assign gain = gainQ;
endmodule

// File: rtl/lms_gain_eq.sv
module lms_gain_eq
  import lms_eq_pkg::*;
#(
  parameter int BACK_W    = 12,
  parameter int OUT_W     = 16,
  parameter int FRAC_W    = 16,
  parameter int SHIFT_W   = 5,
  parameter int MIN_SHIFT = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic                     freeze,
  input  logic [SHIFT_W-1:0]       stepShift,
  input  logic signed [BACK_W-1:0] backA,
  input  logic signed [OUT_W-1:0]  coarseA,
  input  logic signed [OUT_W-1:0]  refB,
  output logic signed [OUT_W-1:0]  outA,
  output logic [FRAC_W:0]          gain
);
  eq_strobe_t strobe;

  lms_eq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .freeze(freeze), .strobe(strobe)
  );

  lms_eq_datapath #(
    .BACK_W(BACK_W), .OUT_W(OUT_W), .FRAC_W(FRAC_W),
    .SHIFT_W(SHIFT_W), .MIN_SHIFT(MIN_SHIFT)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .stepShift(stepShift),
    .backA(backA), .coarseA(coarseA), .refB(refB), .outA(outA), .gain(gain)
  );
endmodule

// File: rtl/lms_gain_eq_chk.sv
module lms_gain_eq_chk #(
  parameter int BACK_W  = 12,
  parameter int OUT_W   = 16,
  parameter int FRAC_W  = 16,
  parameter int SHIFT_W = 5
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     inValid,
  input logic                     freeze,
  input logic [SHIFT_W-1:0]       stepShift,
  input logic signed [BACK_W-1:0] backA,
  input logic signed [OUT_W-1:0]  coarseA,
  input logic signed [OUT_W-1:0]  refB,
  input logic signed [OUT_W-1:0]  outA,
  input logic [FRAC_W:0]          gain
);
  localparam logic [FRAC_W:0] G_ONE = (FRAC_W+1)'(1) << FRAC_W;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (gain == G_ONE && outA == '0));

  assert_backend_only_R2: assert property (@(posedge clk) disable iff (rst)
    (inValid && backA == '0) |=> (outA == $past(coarseA)));

  assert_hold_output_R4: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(outA));

  assert_zero_sign_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(inValid, 2) && $past(backA, 2) == '0) |-> $stable(gain));

  assert_freeze_hold_R8: assert property (@(posedge clk) disable iff (rst)
    $past(freeze) |-> $stable(gain));

  assert_update_timing_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(inValid, 2) |-> $stable(gain));
endmodule

bind lms_gain_eq lms_gain_eq_chk #(
  .BACK_W(BACK_W), .OUT_W(OUT_W), .FRAC_W(FRAC_W), .SHIFT_W(SHIFT_W)
) u_chk (.*);

// File: tb/sim_lms_gain_eq.sv
module sim_lms_gain_eq;
  localparam int BACK_W = 12, OUT_W = 16, FRAC_W = 16, SHIFT_W = 5, MIN_SHIFT = 12;
  localparam longint G_TOP = (64'sd1 <<< (FRAC_W + 1)) - 1;

  logic clk = 1'b0;
  logic rst, inValid, freeze;
  logic [SHIFT_W-1:0] stepShift;
  logic signed [BACK_W-1:0] backA;
  logic signed [OUT_W-1:0] coarseA, refB, outA;
  logic [FRAC_W:0] gain;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  longint gModel;
  longint lastOut;

  always #5ns clk = ~clk;

  lms_gain_eq #(.BACK_W(BACK_W), .OUT_W(OUT_W), .FRAC_W(FRAC_W),
    .SHIFT_W(SHIFT_W), .MIN_SHIFT(MIN_SHIFT)) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .freeze(freeze), .stepShift(stepShift),
    .backA(backA), .coarseA(coarseA), .refB(refB), .outA(outA), .gain(gain));

  function automatic longint expOut(longint b, longint c, longint g);
    longint s = c + ((b * g) >>> FRAC_W);
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  function automatic longint expGain(longint g, longint b, longint c, longint r, int sh);
    longint e = (c <<< FRAC_W) + b * g - (r <<< FRAC_W);
    int k = (sh < MIN_SHIFT) ? MIN_SHIFT : sh;
    longint d = e >>> k;
    longint n = g;
    if (b > 0) n = g - d;
    else if (b < 0) n = g + d;
    if (n < 0) n = 0;
    if (n > G_TOP) n = G_TOP;
    return n;
  endfunction

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1; inValid = 1'b0; freeze = 1'b0; stepShift = '0;
    backA = '0; coarseA = '0; refB = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    gModel = 64'sd1 <<< FRAC_W;
    lastOut = 0;
  endtask

  // one sample: capture edge, then update edge
  task automatic doSample(longint b, longint c, longint r, int sh, bit fz, string tag);
    longint eo, eg;
    backA = BACK_W'(b); coarseA = OUT_W'(c); refB = OUT_W'(r);
    stepShift = SHIFT_W'(sh); freeze = fz; inValid = 1'b1;
    eo = expOut(b, c, gModel);
    eg = fz ? gModel : expGain(gModel, b, c, r, sh);
    @(negedge clk);
    check(tag, "outA", longint'(outA), eo);
    inValid = 1'b0;
    @(negedge clk);
    check(tag, "gain", longint'(gain), eg);
    check("R4", "outA held", longint'(outA), eo);
    gModel = eg; lastOut = eo;
    freeze = 1'b0;
  endtask

  initial begin
    longint gt, b, c, diff;
    void'($urandom(32'd4242));
    rst = 1'b1; inValid = 1'b0; freeze = 1'b0; stepShift = '0;
    backA = '0; coarseA = '0; refB = '0;
    doReset();
    // R1 reset state
    check("R1", "gain after reset", longint'(gain), 64'sd1 <<< FRAC_W);
    check("R1", "outA after reset", longint'(outA), 0);

    // R2 basic scaling, positive and negative backend
    doSample(1000, 5000, 6000, 16, 1'b0, "R2");
    doSample(-777, -3000, -3777, 16, 1'b0, "R2");
    // R5 zero backend leaves gain
    doSample(0, 1234, -20000, 12, 1'b0, "R5");
    // R3 saturation both ways
    doReset();
    doSample(2047, 32767, 32767, 31, 1'b1, "R3");
    check("R3", "outA upper limit", longint'(outA), 32767);
    doSample(-2047, -32768, -32768, 31, 1'b1, "R3");
    check("R3", "outA lower limit", longint'(outA), -32768);

    // R6 shift floor: stepShift 0 acts as MIN_SHIFT
    doReset();
    doSample(1, 100, 0, 0, 1'b0, "R6");
    check("R6", "gain with clamped shift", longint'(gain), 65536 - 1616);
    doReset();
    doSample(1, 100, 0, 14, 1'b0, "R6");
    check("R6", "gain with shift 14", longint'(gain), 65536 - 404);

    // R8 freeze
    doReset();
    doSample(2000, 10000, -20000, 12, 1'b1, "R8");
    check("R8", "gain frozen", longint'(gain), 64'sd1 <<< FRAC_W);
    doSample(2000, 10000, -20000, 12, 1'b0, "R8");

    // R7 saturation of the gain
    doReset();
    doSample(2047, 0, -32768, 12, 1'b0, "R7");
    check("R7", "gain floor", longint'(gain), 0);
    doReset();
    doSample(-2047, 0, -32768, 12, 1'b0, "R7");
    check("R7", "gain ceiling", longint'(gain), G_TOP);

    // R9 convergence from a known mismatch, per-sample model checks
    doReset();
    gt = 62259;
    for (int i = 0; i < 3000; i++) begin
      b = longint'($urandom_range(4000)) - 2000;
      c = longint'($urandom_range(40000)) - 20000;
      doSample(b, c, c + ((b * gt) >>> FRAC_W), 13, 1'b0, "R5");
    end
    diff = longint'(gain) - gt;
    if (diff < 0) diff = -diff;
    checks++;
    if (diff > 96) begin
      fails++;
      $display("FAIL R9 settled gain actual %0d expected %0d +/-96", gain, gt);
    end

    // upward mismatch, fewer samples
    gt = 68157;
    for (int i = 0; i < 1500; i++) begin
      b = longint'($urandom_range(4000)) - 2000;
      c = longint'($urandom_range(40000)) - 20000;
      doSample(b, c, c + ((b * gt) >>> FRAC_W), 12, 1'b0, "R5");
    end
    diff = longint'(gain) - gt;
    if (diff < 0) diff = -diff;
    checks++;
    if (diff > 96) begin
      fails++;
      $display("FAIL R9 settled gain actual %0d expected %0d +/-96", gain, gt);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule